// File: doc/BRIEF.md
# Serial Memory Slave Front End with Transfer Pause

This block is the bit-level front end of a serial memory slave. The link uses clock polarity 0 and phase 0. The block oversamples the serial clock, select, pause and data pins on a local system clock. Input bits are collected most significant bit first, and each completed byte is handed to the memory core with a one-cycle strobe. Outgoing bytes are taken from the core at the same byte boundaries and shifted out on the data output, which has its own enable.

A pause input lets the master freeze a transfer part-way through a byte. A pause request is honoured only while the serial clock is low. If the clock is high when the pause pin changes, the change waits until the clock next goes low. While paused, the output enable is off, clock and data activity is ignored, and the whole transfer state is kept until the pause ends. If the master releases select during a pause, the interface resets and the core sees a one-cycle abort pulse. After that, the block accepts no new transfer until the pause pin has gone high while the block is deselected, and select then falls again.

Top module: `spi_hold_front`

## Requirements
- R1: Input data is sampled on the synchronised rising edge of the serial clock, most significant bit first. After every eighth sampled bit, `rx_valid` pulses for one cycle with the assembled byte on `rx_byte`.
- R2: The most significant bit of the outgoing byte is on `so` before the first rising clock edge of a transfer. Each later falling edge within a byte moves `so` to the next lower bit.
- R3: `tx_load` pulses once when select falls and once at each byte boundary. At each pulse the current `tx_byte` is captured as the next outgoing byte. A transfer of N bytes therefore produces N+1 pulses.
- R4: A pause pin falling edge while the clock is low starts the pause within SYNC_STAGES+2 cycles, and `so_oe` turns off.
- R5: A pause pin falling edge while the clock is high does not start the pause. The pause starts once the clock next goes low.
- R6: The pause ends when the pause pin is high and the clock is low. A release that happens while the clock is high takes effect at the next clock low.
- R7: While paused, clock edges and data-pin changes do not advance the bit count or the shift state. After the pause, the interrupted byte completes with both its input and output bits intact.
- R8: Select high turns `so_oe` off, clears the bit count and discards any partial byte. The next transfer starts at a byte boundary.
- R9: Select rising during a pause produces exactly one `abort` pulse. Select rising with no pause active produces none.
- R10: After an abort, a select falling edge while the pause pin is still low starts no transfer: `so_oe` stays off and no bytes are delivered. Raising the pause pin while deselected, then selecting, restores normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| rx_valid | output | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | output | BYTE_W | Last received byte |
| tx_byte | input | BYTE_W | Next byte to transmit, supplied by the core |
| tx_load | output | 1 | One-cycle strobe: `tx_byte` has been captured |
| abort | output | 1 | One-cycle pulse: transfer cancelled by deselect during pause |

## Verification
The bench builds the block with its defaults: BYTE_W of 8 and SYNC_STAGES of 2. It drives each serial clock phase for six system cycles, which is longer than the SYNC_STAGES+2 latency. This makes the output-enable and data-out timing around pause edges observable at the ports. With these values the bench can trigger a pause from either clock level, release it from either level, and resume a byte split at bit three. It also covers a partial byte cut off by deselect and the abort, stale-pause and reselect sequence, alongside seeded random multi-byte transfers.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

   typedef struct packed {
      logic cs_n;
      logic hold_n;
      logic sck;
      logic si;
   } spi_pins_t;

   localparam int PIN_COUNT = $bits(spi_pins_t);
   localparam spi_pins_t PIN_IDLE = '{cs_n: 1'b1, hold_n: 1'b1, sck: 1'b0, si: 1'b0};

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int              WIDTH   = 4,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
            end else begin
               st[0] <= d;
               for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic hold_n_s,
   input  logic sck_s,
   output logic session_ok,
   output logic hold_on,
   output logic start,
   output logic abort,
   output logic lockout
);

   logic cs_q;

   assign start = cs_q & ~cs_n_s & ~lockout;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q       <= 1'b1;
         session_ok <= 1'b0;
         hold_on    <= 1'b0;
         abort      <= 1'b0;
         lockout    <= 1'b0;
      end else begin
         cs_q  <= cs_n_s;
         abort <= 1'b0;
         if (cs_n_s) begin
            if (session_ok && hold_on) begin
               abort   <= 1'b1;
               lockout <= 1'b1;
            end else if (hold_n_s) begin
               lockout <= 1'b0;
            end
            session_ok <= 1'b0;
            hold_on    <= 1'b0;
         end else if (start) begin
            session_ok <= 1'b1;
            hold_on    <= 1'b0;
         end else if (session_ok && !sck_s) begin
            hold_on <= ~hold_n_s;
         end
      end
   end

   a_r9_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !abort);

   a_r5_entry_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_on) |-> $past(!sck_s));

   a_r6_exit_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hold_on) && $past(!cs_n_s)) |-> $past(!sck_s));

   a_r10_locked_idle: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |-> !session_ok);

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              frozen,
   input  logic              start,
   input  logic              rise,
   input  logic              fall,
   input  logic              si_s,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              so,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              tx_load,
   output logic [CNT_W-1:0]  cnt
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic              fresh;
   logic [BYTE_W-1:0] rx_next;

   assign rx_next = {rx_sh[BYTE_W-2:0], si_s};
   assign so      = tx_sh[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         fresh    <= 1'b0;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
         tx_load  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_load  <= 1'b0;
         if (start) begin
            cnt     <= '0;
            rx_sh   <= '0;
            fresh   <= 1'b0;
            tx_sh   <= tx_byte;
            tx_load <= 1'b1;
         end else if (!active) begin
            cnt   <= '0;
            rx_sh <= '0;
            fresh <= 1'b0;
         end else if (!frozen) begin
            if (rise) begin
               rx_sh <= rx_next;
               if (cnt == LAST) begin
                  cnt      <= '0;
                  rx_valid <= 1'b1;
                  rx_byte  <= rx_next;
                  tx_sh    <= tx_byte;
                  tx_load  <= 1'b1;
                  fresh    <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else if (fall) begin
               if (fresh) fresh <= 1'b0;
               else       tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   a_r1_valid_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (cnt == '0));

   a_r3_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_load);

endmodule

// File: rtl/spi_hold_front.sv
module spi_hold_front #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              si,
   input  logic              cs_n,
   input  logic              hold_n,
   output logic              so,
   output logic              so_oe,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_byte,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              tx_load,
   output logic              abort
);
   import spi_hold_pkg::*;

   localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("spi_hold_front: BYTE_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("spi_hold_front: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   spi_pins_t  pin_raw, pin_s;
   logic       sck_q, rise, fall;
   logic       session_ok, hold_on, start, lockout;
   logic [CNT_W-1:0] cnt;

   assign pin_raw = '{cs_n: cs_n, hold_n: hold_n, sck: sck, si: si};

   spi_pin_sync #(
      .WIDTH  (PIN_COUNT),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_raw),
      .q    (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= pin_s.sck;
   end

   assign rise = pin_s.sck & ~sck_q;
   assign fall = ~pin_s.sck & sck_q;

   spi_hold_ctrl u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (pin_s.cs_n),
      .hold_n_s  (pin_s.hold_n),
      .sck_s     (pin_s.sck),
      .session_ok(session_ok),
      .hold_on   (hold_on),
      .start     (start),
      .abort     (abort),
      .lockout   (lockout)
   );

   spi_shift_core #(.BYTE_W(BYTE_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (session_ok),
      .frozen  (hold_on),
      .start   (start),
      .rise    (rise),
      .fall    (fall),
      .si_s    (pin_s.si),
      .tx_byte (tx_byte),
      .so      (so),
      .rx_valid(rx_valid),
      .rx_byte (rx_byte),
      .tx_load (tx_load),
      .cnt     (cnt)
   );

   assign so_oe = session_ok & ~hold_on;

   a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_on && session_ok && !pin_s.cs_n) |=> $stable(cnt));

   a_r8_clear_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_s.cs_n && $past(pin_s.cs_n)) |=> (cnt == '0 && !rx_valid));

   a_r10_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (lockout && !session_ok) |=> !rx_valid);

endmodule

// File: tb/spi_hold_front_test.sv
module spi_hold_front_test;

   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n, sck, si, cs_n, hold_n;
   logic       so, so_oe, rx_valid, tx_load, abort;
   logic [7:0] rx_byte, tx_byte;

   int checks = 0;
   int errors = 0;
   int rx_n   = 0;
   int tx_idx = 0;
   int ab_n   = 0;
   logic [7:0] rx_log [64];
   bit done = 1'b0;

   always #10 clk = ~clk;

   spi_hold_front uut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
      .so(so), .so_oe(so_oe), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .tx_byte(tx_byte), .tx_load(tx_load), .abort(abort)
   );

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 73 + 29) ^ 8'h5A);
   endfunction

   assign tx_byte = pat(tx_idx);

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_log[rx_n % 64] = rx_byte;
         rx_n = rx_n + 1;
      end
      if (tx_load) tx_idx = tx_idx + 1;
      if (abort)   ab_n = ab_n + 1;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rise_bit(input logic b, output logic s);
      si = b;
      s  = so;
      sck = 1'b1;
      wclk(HALF);
   endtask

   task automatic fall_bit;
      sck = 1'b0;
      wclk(HALF);
   endtask

   task automatic bit_xfer(input logic b, output logic s);
      rise_bit(b, s);
      fall_bit();
   endtask

   task automatic byte_xfer(input logic [7:0] d, output logic [7:0] q);
      for (int i = 7; i >= 0; i--) bit_xfer(d[i], q[i]);
   endtask

   task automatic select;
      cs_n = 1'b0;
      wclk(HALF);
   endtask

   task automatic deselect;
      cs_n = 1'b1;
      wclk(HALF);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      logic [7:0] d, q;
      int base, n0, nb, ab0;
      logic dummy;
      void'($urandom(32'd4711));
      rst_n = 1'b0; cs_n = 1'b1; hold_n = 1'b1; sck = 1'b0; si = 1'b0;
      wclk(4);
      rst_n = 1'b1;
      wclk(4);
      // R8 reset state
      check(so_oe == 1'b0, "R8 reset so_oe", so_oe, 0);
      check(rx_n == 0 && ab_n == 0, "R8 reset strobes", rx_n + ab_n, 0);

      // R1 R2 R3 random multi-byte transfers
      for (int s = 0; s < 4; s++) begin
         nb = 1 + int'($urandom % 3);
         base = tx_idx;
         select();
         check(so_oe == 1'b1, "R2 so_oe on select", so_oe, 1);
         for (int j = 0; j < nb; j++) begin
            d = 8'($urandom);
            n0 = rx_n;
            byte_xfer(d, q);
            check(rx_n == n0 + 1 && rx_log[n0 % 64] == d, "R1 rx byte", rx_log[n0 % 64], d);
            check(q == pat(base + j), "R2 tx byte", q, pat(base + j));
         end
         check(tx_idx == base + nb + 1, "R3 load count", tx_idx - base, nb + 1);
         deselect();
      end
      check(ab_n == 0, "R9 no abort without hold", ab_n, 0);

      // R8 partial byte discarded
      base = tx_idx;
      select();
      n0 = rx_n;
      for (int i = 0; i < 5; i++) bit_xfer(1'($urandom), dummy);
      deselect();
      check(so_oe == 1'b0, "R8 so_oe off", so_oe, 0);
      check(rx_n == n0, "R8 no partial byte", rx_n - n0, 0);
      base = tx_idx;
      select();
      d = 8'hA7;
      byte_xfer(d, q);
      check(rx_n == n0 + 1 && rx_log[n0 % 64] == d, "R8 fresh byte after cut", rx_log[n0 % 64], d);
      check(q == pat(base), "R8 tx restarts", q, pat(base));
      deselect();

      // R4 R6 R7 hold entered and left with sck low
      base = tx_idx;
      select();
      n0 = rx_n;
      d = 8'($urandom);
      for (int i = 7; i >= 5; i--) bit_xfer(d[i], q[i]);
      hold_n = 1'b0;
      wclk(5);
      check(so_oe == 1'b0, "R4 immediate hold", so_oe, 0);
      repeat (3) begin
         si = 1'($urandom);
         sck = 1'b1; wclk(HALF);
         sck = 1'b0; wclk(HALF);
      end
      check(rx_n == n0, "R7 no byte during hold", rx_n - n0, 0);
      hold_n = 1'b1;
      wclk(5);
      check(so_oe == 1'b1, "R6 immediate release", so_oe, 1);
      for (int i = 4; i >= 0; i--) bit_xfer(d[i], q[i]);
      check(rx_n == n0 + 1 && rx_log[n0 % 64] == d, "R7 rx resumes", rx_log[n0 % 64], d);
      check(q == pat(base), "R7 tx resumes", q, pat(base));
      deselect();

      // R5 R6 R7 hold requested and released with sck high
      base = tx_idx;
      select();
      n0 = rx_n;
      d = 8'($urandom);
      for (int i = 7; i >= 6; i--) bit_xfer(d[i], q[i]);
      rise_bit(d[5], q[5]);
      hold_n = 1'b0;
      wclk(8);
      check(so_oe == 1'b1, "R5 hold deferred while sck high", so_oe, 1);
      fall_bit();
      check(so_oe == 1'b0, "R5 hold after sck low", so_oe, 0);
      si = 1'($urandom);
      sck = 1'b1; wclk(HALF);
      sck = 1'b0; wclk(HALF);
      sck = 1'b1; wclk(HALF);
      hold_n = 1'b1;
      wclk(8);
      check(so_oe == 1'b0, "R6 release deferred while sck high", so_oe, 0);
      sck = 1'b0;
      wclk(HALF);
      check(so_oe == 1'b1, "R6 release after sck low", so_oe, 1);
      for (int i = 4; i >= 0; i--) bit_xfer(d[i], q[i]);
      check(rx_n == n0 + 1 && rx_log[n0 % 64] == d, "R7 rx after deferred hold", rx_log[n0 % 64], d);
      check(q == pat(base), "R7 tx after deferred hold", q, pat(base));
      deselect();

      // R9 R10 abort, stale hold, reselect
      select();
      for (int i = 0; i < 3; i++) bit_xfer(1'($urandom), dummy);
      hold_n = 1'b0;
      wclk(5);
      ab0 = ab_n;
      cs_n = 1'b1;
      wclk(HALF);
      check(ab_n == ab0 + 1, "R9 abort pulse", ab_n - ab0, 1);
      check(so_oe == 1'b0, "R9 so_oe off after abort", so_oe, 0);
      cs_n = 1'b0;
      wclk(HALF);
      check(so_oe == 1'b0, "R10 locked select", so_oe, 0);
      n0 = rx_n;
      base = tx_idx;
      byte_xfer(8'h3C, q);
      check(rx_n == n0, "R10 no byte while locked", rx_n - n0, 0);
      check(tx_idx == base, "R10 no load while locked", tx_idx - base, 0);
      cs_n = 1'b1;
      wclk(HALF);
      hold_n = 1'b1;
      wclk(HALF);
      base = tx_idx;
      select();
      check(so_oe == 1'b1, "R10 reselect enables", so_oe, 1);
      d = 8'($urandom);
      n0 = rx_n;
      byte_xfer(d, q);
      check(rx_n == n0 + 1 && rx_log[n0 % 64] == d, "R10 rx after reselect", rx_log[n0 % 64], d);
      check(q == pat(base), "R10 tx after reselect", q, pat(base));
      deselect();
      check(ab_n == ab0 + 1, "R9 single abort overall", ab_n - ab0, 1);

      wclk(4);
      report();
   end

endmodule